// File: doc/BRIEF.md
# Two-Phase Clock Generator with Phase-Aligned Reset

This block turns one fast input clock into a half-rate, non-overlapping clock pair for a processor core: a primary phase (`phi1`) and its complement (`phi2`). It also provides a system copy of the primary phase (`cttl`), a buffered copy of the fast clock (`fclk`), and a one-cycle enable (`phi1_rise`) that marks each new high phase of `phi1` for downstream bus logic. Every phase output is a registered level that changes on rising edges of the fast clock. Each phase therefore lasts exactly one input cycle.

An asynchronous active-low reset input is first passed through a flop synchronizer. It is then turned into a reset output that drops at once and is released only together with a rising edge of `phi1`. While the reset output is low, a `sync_in` input lets several such blocks line up their divide-by-two phase. A high sample delays the primary phase by one input cycle if it is already high, and forces it high if it is low. The same input therefore serves a slave that follows a master's clock and a unit that locks to a single external pulse. Once the reset output is high, `sync_in` has no effect.

Top module: `twophase_clkgen`

## Requirements
- R1: Outside reset `phi1` inverts on every rising edge of `clk`, so it runs at half the input rate, and `phi2` is its complement. `fclk` is a copy of `clk`.
- R2: `phi1` and `phi2` are never high at the same time.
- R3: `cttl` equals `phi1` in every cycle.
- R4: While `rst_out_n` is low, a rising edge of `clk` that samples `sync_in` high while `phi1` is high leaves `phi1` high (and `phi2` low) for one more cycle.
- R5: While `rst_out_n` is low, a rising edge of `clk` that samples `sync_in` high while `phi1` is low makes `phi1` high after that edge. A single-edge pulse therefore fixes the phase whatever it was before.
- R6: Holding `sync_in` high during reset freezes `phi1` high. `rst_out_n` then stays low even after `rst_in_n` has returned high.
- R7: A low level on `rst_in_n` drives `rst_out_n` low at once, without waiting for a clock edge, and clears `phi1_rise`.
- R8: After `rst_in_n` rises, `rst_out_n` goes high on the first rising edge of `clk` that makes `phi1` rise and that is at least SYNC_STAGES+1 edges later (the third edge with the default of 2).
- R9: While `rst_out_n` is high, `sync_in` has no effect on `phi1`.
- R10: `phi1_rise` is high for exactly the one input cycle in which `phi1` has just gone from low to high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock, twice the phase rate |
| rst_in_n | input | 1 | Asynchronous reset request, active low |
| sync_in | input | 1 | Phase alignment request, honoured only while `rst_out_n` is low |
| fclk | output | 1 | Buffered copy of `clk` |
| phi1 | output | 1 | Primary half-rate phase |
| phi2 | output | 1 | Complementary half-rate phase |
| cttl | output | 1 | System copy of `phi1` |
| rst_out_n | output | 1 | Reset output, active low, released with a `phi1` rising edge |
| phi1_rise | output | 1 | One-cycle enable in the cycle after each `phi1` rising edge |

## Verification
The hardest situation to reach from the ports is the release of the reset output. Its timing depends on both the synchronizer depth and on which phase the divider happens to be in when `rst_in_n` rises. The bench first pins the phase with a single `sync_in` pulse or by waiting for a known `phi1` level. It then releases `rst_in_n` once from each phase, so that one release lands on the third edge and the other must skip an early `phi1` rise and land on the fourth. The frozen case is reached by holding `sync_in` high across the release of `rst_in_n`. The bench then drops it and expects release two edges later.

// File: rtl/twophase_pkg.sv
package twophase_pkg;

  // Phase value that the divider takes at the next clk edge.
  // In reset a high alignment request parks the phase high; otherwise it inverts.
  function automatic logic phase_next(input logic cur, input logic in_reset,
                                      input logic align_req);
    logic nxt;
    if (in_reset && align_req) nxt = 1'b1;
    else                       nxt = ~cur;
    return nxt;
  endfunction

  // True when the coming edge takes the phase from low to high.
  function automatic logic is_rising(input logic cur, input logic nxt);
    return (~cur) & nxt;
  endfunction

endpackage

// File: rtl/tpc_reset_sync.sv
module tpc_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_sync_n
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_in_n) begin
          if (!rst_in_n) chain_q[gi] <= 1'b0;
          else           chain_q[gi] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_in_n) begin
          if (!rst_in_n) chain_q[gi] <= 1'b0;
          else           chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[LAST];
endmodule

// File: rtl/tpc_phase_core.sv
module tpc_phase_core
  import twophase_pkg::*;
(
  input  logic clk,
  input  logic rst_in_n,
  input  logic in_reset,
  input  logic sync_in,
  output logic phi1,
  output logic phi2,
  output logic cttl,
  output logic phi1_rise,
  output logic rise_evt
);
  // The divider keeps no reset so that it runs throughout reset; its phase is
  // fixed by an alignment request or simply accepted as found.
  logic phase_q;
  logic phase_d;
  logic phi1_q, phi2_q, cttl_q, rise_q;

  assign phase_d  = phase_next(phase_q, in_reset, sync_in);
  assign rise_evt = is_rising(phase_q, phase_d);

  always_ff @(posedge clk) begin
    phase_q <= phase_d;
    phi1_q  <= phase_d;
    phi2_q  <= ~phase_d;
    cttl_q  <= phase_d;
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) rise_q <= 1'b0;
    else           rise_q <= rise_evt;
  end

  assign phi1      = phi1_q;
  assign phi2      = phi2_q;
  assign cttl      = cttl_q;
  assign phi1_rise = rise_q;
endmodule

// File: rtl/tpc_reset_release.sv
module tpc_reset_release (
  input  logic clk,
  input  logic rst_in_n,
  input  logic rst_sync_n,
  input  logic rise_evt,
  output logic rst_out_n
);
  logic out_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n)                    out_q <= 1'b0;
    else if (rst_sync_n && rise_evt)  out_q <= 1'b1;
  end

  assign rst_out_n = out_q;
endmodule

// File: rtl/twophase_clkgen.sv
module twophase_clkgen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  input  logic sync_in,
  output logic fclk,
  output logic phi1,
  output logic phi2,
  output logic cttl,
  output logic rst_out_n,
  output logic phi1_rise
);
  localparam int STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic rst_sync_n;
  logic phase_rise_evt;
  logic in_reset;

  assign in_reset = ~rst_out_n;
  assign fclk     = clk;

  tpc_reset_sync #(.STAGES(STAGES)) u_rsync (
    .clk        (clk),
    .rst_in_n   (rst_in_n),
    .rst_sync_n (rst_sync_n)
  );

  tpc_phase_core u_core (
    .clk       (clk),
    .rst_in_n  (rst_in_n),
    .in_reset  (in_reset),
    .sync_in   (sync_in),
    .phi1      (phi1),
    .phi2      (phi2),
    .cttl      (cttl),
    .phi1_rise (phi1_rise),
    .rise_evt  (phase_rise_evt)
  );

  tpc_reset_release u_rel (
    .clk        (clk),
    .rst_in_n   (rst_in_n),
    .rst_sync_n (rst_sync_n),
    .rise_evt   (phase_rise_evt),
    .rst_out_n  (rst_out_n)
  );
endmodule

// File: rtl/twophase_clkgen_chk.sv
module twophase_clkgen_chk (
  input logic clk,
  input logic rst_in_n,
  input logic sync_in,
  input logic phi1,
  input logic phi2,
  input logic cttl,
  input logic rst_out_n,
  input logic phi1_rise
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!started)
    !(phi1 && phi2));

  a_r3_cttl_tracks: assert property (@(posedge clk) disable iff (!started)
    cttl == phi1);

  a_r1_toggle_high: assert property (@(posedge clk) disable iff (!rst_out_n)
    phi1 |=> !phi1);

  a_r1_toggle_low: assert property (@(posedge clk) disable iff (!rst_out_n)
    !phi1 |=> phi1);

  a_r4_slip: assert property (@(posedge clk) disable iff (!started)
    (!rst_out_n && sync_in && phi1) |=> phi1);

  a_r5_force: assert property (@(posedge clk) disable iff (!started)
    (!rst_out_n && sync_in && !phi1) |=> phi1);

  a_r7_hold_low: assert property (@(posedge clk) disable iff (!started)
    !rst_in_n |-> !rst_out_n);

  a_r8_release_on_rise: assert property (@(posedge clk) disable iff (!started || !rst_in_n)
    $rose(rst_out_n) |-> $rose(phi1));

  a_r10_pulse: assert property (@(posedge clk) disable iff (!started)
    phi1_rise |-> (phi1 && !$past(phi1)));
endmodule

bind twophase_clkgen twophase_clkgen_chk u_chk (.*);

// File: tb/twophase_clkgen_bench.sv
module twophase_clkgen_bench;
  logic clk = 1'b0;
  logic rst_in_n, sync_in;
  logic fclk, phi1, phi2, cttl, rst_out_n, phi1_rise;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  twophase_clkgen u_twophase_clkgen (
    .clk(clk), .rst_in_n(rst_in_n), .sync_in(sync_in), .fclk(fclk),
    .phi1(phi1), .phi2(phi2), .cttl(cttl), .rst_out_n(rst_out_n),
    .phi1_rise(phi1_rise)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wait_phi(input logic v);
    for (int i = 0; i < 4 && phi1 !== v; i++) step();
  endtask

  task automatic t_reset_state();
    step(); step(); step();
    chk("R7 rst_out low in reset", rst_out_n, 1'b0);
    chk("R7 phi1_rise low in reset", phi1_rise, 1'b0);
  endtask

  task automatic t_clocks();
    for (int i = 0; i < 6; i++) begin
      logic prev;
      prev = phi1;
      step();
      chk("R1 phi1 inverts each edge", phi1, ~prev);
      chk("R1 phi2 complement", phi2, ~phi1);
      chk("R2 no overlap", phi1 & phi2, 1'b0);
      chk("R3 cttl equals phi1", cttl, phi1);
    end
    chk("R1 fclk low at clk low", fclk, 1'b0);
    @(posedge clk); #1;
    chk("R1 fclk high at clk high", fclk, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_force();
    wait_phi(1'b0);
    sync_in = 1'b1;
    step();
    chk("R5 forced high", phi1, 1'b1);
    sync_in = 1'b0;
    step();
    chk("R5 resumes low", phi1, 1'b0);
    step();
    chk("R5 resumes high", phi1, 1'b1);
  endtask

  task automatic t_slip();
    wait_phi(1'b1);
    sync_in = 1'b1;
    step();
    chk("R4 phi1 held high", phi1, 1'b1);
    chk("R4 phi2 held low", phi2, 1'b0);
    sync_in = 1'b0;
    step();
    chk("R4 low after slip", phi1, 1'b0);
    step();
    chk("R4 high after slip", phi1, 1'b1);
  endtask

  task automatic t_freeze();
    sync_in = 1'b1;
    step();
    rst_in_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R6 phi1 frozen high", phi1, 1'b1);
      chk("R6 rst_out stays low", rst_out_n, 1'b0);
    end
    sync_in = 1'b0;
    step();
    chk("R8 phi1 low after unfreeze", phi1, 1'b0);
    chk("R8 rst_out still low", rst_out_n, 1'b0);
    step();
    chk("R8 phi1 rises", phi1, 1'b1);
    chk("R8 rst_out released with phi1", rst_out_n, 1'b1);
    chk("R10 pulse at release rise", phi1_rise, 1'b1);
  endtask

  task automatic t_pulse();
    for (int i = 0; i < 6; i++) begin
      logic prev;
      prev = phi1;
      step();
      chk("R10 phi1_rise one cycle", phi1_rise, phi1 & ~prev);
    end
  endtask

  task automatic t_ignore();
    for (int i = 0; i < 4; i++) begin
      logic prev;
      prev = phi1;
      sync_in = 1'b1;
      step();
      chk("R9 sync ignored, phi1 inverts", phi1, ~prev);
      chk("R9 rst_out stays high", rst_out_n, 1'b1);
    end
    sync_in = 1'b0;
  endtask

  task automatic t_async();
    #2 rst_in_n = 1'b0;
    #1;
    chk("R7 rst_out drops without edge", rst_out_n, 1'b0);
    chk("R7 phi1_rise cleared", phi1_rise, 1'b0);
    @(negedge clk);
    step();
  endtask

  task automatic t_release(input logic start);
    int rel_k;
    rel_k = 0;
    for (int k = 3; k < 8 && rel_k == 0; k++) begin
      logic now_v, before_v;
      now_v    = (k % 2 == 1) ? ~start : start;
      before_v = ~now_v;
      if (now_v && !before_v) rel_k = k;
    end
    wait_phi(start);
    rst_in_n = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      step();
      chk("R1 phi1 phase after release", phi1, (k % 2 == 1) ? ~start : start);
      chk("R8 rst_out release edge", rst_out_n, (k >= rel_k) ? 1'b1 : 1'b0);
    end
  endtask

  initial begin
    rst_in_n = 1'b0;
    sync_in  = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_clocks();
    t_force();
    t_slip();
    t_freeze();
    t_pulse();
    t_ignore();
    t_async();
    t_release(1'b0);
    t_async();
    t_release(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule